// File: doc/BRIEF.md
# Output Stage Protection and Start-up Sequencer

This block is the control sequencer for a class-D output stage made of four half-bridges in two bridge pairs. It watches the hardware reset pin, the power-down pin and an external error line from a back-end stage, all active-low. It also watches digital flags from the analog protection circuits: overcurrent on either bridge pair, overtemperature with a separate cool-down flag, and low supply. From these inputs it decides whether the stage switches normally, is held silent, is forced low, or is released to high impedance. Every delay is counted in cycles of the system clock.

Each input is resynchronised before the state machine uses it. Each kind of fault has its own recovery policy. An overcurrent is held until the next reset pulse. An overtemperature fault clears only once the cool-down flag arrives. A supply fault clears as soon as the supply is good again. An external error forces the outputs low for a fixed hold time, and normal operation returns only if the error line is high by then. Leaving reset and leaving power-down use separate start-up delays. The configuration captured at reset survives a power-down cycle.

Top module: `pstg_seq`

## Requirements
- R1: While `rst` is high, and afterwards while `hw_reset_n` stays low, the output vector {valid, fault_n, hiz_en, outs_low, hard_mute} is 00001.
- R2: Every pin input passes through a two-flop synchroniser. A change at a pin is seen at the outputs after the third rising clock edge and not after the second.
- R3: A low `hw_reset_n` forces hard mute (vector 00001) from any state, including fault and external-error states. Reset outranks every other input.
- R4: When `hw_reset_n` is released with `sleep_n` high, the block stays muted for INIT_CYC cycles and then runs (vector 11000).
- R5: When `hw_reset_n` is released with `sleep_n` low, the block stays muted for as long as `sleep_n` stays low. Its release then starts the soft start.
- R6: A low `sleep_n` mutes the stage. When it goes high again, the soft start runs for SOFT_CYC cycles with vector 00000, and then the block runs.
- R7: A high `oc_ab` or `oc_cd` gives vector 00100 (high impedance, fault reported). This fault is latched and survives removal of the flag. Only a pulse on `hw_reset_n` clears it, and the block then goes through the INIT_CYC start-up.
- R8: A high `temp_hot` gives vector 00100 even if it is only a pulse. The fault holds until `temp_cool` goes high. The block then soft-starts and runs.
- R9: A high `supply_low` gives vector 00100 for as long as the flag is present. When the flag drops, the block soft-starts and runs.
- R10: A low `ext_err_n` while running gives vector 00010 for exactly HOLD_CYC cycles. If the line is high by then, the block returns straight to running.
- R11: If `ext_err_n` is still low when the hold time ends, the outputs stay low. The block runs again after the line goes high, with the same latency as in R2.
- R12: `valid` and `fault_n` are high only while running with no active condition. At most one of valid, hiz_en, outs_low and hard_mute is high at any time.
- R13: Priority when inputs coincide: reset, then fault, then power-down, then external error. A fault together with an external error gives 00100. When the fault clears while `sleep_n` is still low, the vector becomes 00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the logic |
| hw_reset_n | input | 1 | Asynchronous reset pin, active-low |
| sleep_n | input | 1 | Asynchronous power-down pin, active-low |
| ext_err_n | input | 1 | Asynchronous back-end error, active-low |
| oc_ab | input | 1 | Overcurrent flag, bridge pair A/B |
| oc_cd | input | 1 | Overcurrent flag, bridge pair C/D |
| temp_hot | input | 1 | Die temperature above trip point |
| temp_cool | input | 1 | Die temperature below hysteresis point |
| supply_low | input | 1 | Some supply below its threshold |
| valid | output | 1 | Output stage valid, all channels |
| fault_n | output | 1 | Fault report, low unless running cleanly |
| hiz_en | output | 1 | Put all half-bridges in high impedance |
| outs_low | output | 1 | Drive all half-bridge outputs low |
| hard_mute | output | 1 | Switching stopped |

## Verification
The collisions that matter are a protection fault arriving on the same clock edge as an external error, and a supply fault arriving together with power-down. The bench provokes each one by changing both pins on the same falling edge while the block is running. Three edges later it requires the fault state to win, with high impedance and no outputs-low command. For the power-down case it then removes only the supply flag. The vector must then fall back to hard mute, which shows that power-down still holds underneath the cleared fault.

// File: rtl/pstg_pkg.sv
package pstg_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_INIT  = 3'd1,
        ST_PDOWN = 3'd2,
        ST_SOFT  = 3'd3,
        ST_RUN   = 3'd4,
        ST_BKERR = 3'd5,
        ST_FAULT = 3'd6
    } pstg_state_e;

    typedef struct packed {
        logic valid;
        logic fault_n;
        logic hiz_en;
        logic outs_low;
        logic hard_mute;
    } pstg_out_t;

    // bit positions inside the synchroniser vector
    localparam int IN_RST  = 0;
    localparam int IN_PDN  = 1;
    localparam int IN_ERR  = 2;
    localparam int IN_OCAB = 3;
    localparam int IN_OCCD = 4;
    localparam int IN_HOT  = 5;
    localparam int IN_COOL = 6;
    localparam int IN_LOW  = 7;
    localparam int IN_NUM  = 8;
    // idle levels: power-down and error lines idle high, reset pin held low
    localparam logic [IN_NUM-1:0] IN_IDLE = 8'b0000_0110;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic pstg_out_t decode(input pstg_state_e st);
        pstg_out_t o;
        o = '0;
        o.valid     = (st == ST_RUN);
        o.fault_n   = (st == ST_RUN);
        o.hiz_en    = (st == ST_FAULT);
        o.outs_low  = (st == ST_BKERR);
        o.hard_mute = (st == ST_RESET) || (st == ST_INIT) || (st == ST_PDOWN);
        return o;
    endfunction

endpackage

// File: rtl/pstg_sync.sv
module pstg_sync #(
    parameter int                W       = 8,
    parameter int                STAGES  = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= din;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pstg_timer.sv
module pstg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= ld_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
        done && !load |=> done); // R10
endmodule

// File: rtl/pstg_fault_trk.sv
module pstg_fault_trk (
    input  logic clk,
    input  logic rst,
    input  logic rst_n_s,
    input  logic oc_ab_s,
    input  logic oc_cd_s,
    input  logic hot_s,
    input  logic cool_s,
    input  logic low_s,
    output logic active
);
    logic oc_latched;
    logic ot_latched;
    logic oc_now;

    assign oc_now = oc_ab_s | oc_cd_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_latched <= 1'b0;
            ot_latched <= 1'b0;
        end else begin
            if (oc_now)
                oc_latched <= 1'b1;
            else if (!rst_n_s)
                oc_latched <= 1'b0;

            if (hot_s)
                ot_latched <= 1'b1;
            else if (cool_s)
                ot_latched <= 1'b0;
        end
    end

    // next-value view so release and trip take the same latency
    assign active = oc_now | oc_latched | hot_s | (ot_latched & ~cool_s) | low_s;

    AST_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
        oc_latched && rst_n_s |=> oc_latched); // R7
    AST_OT_STICKY: assert property (@(posedge clk) disable iff (rst)
        ot_latched && !cool_s |=> ot_latched); // R8
endmodule

// File: rtl/pstg_seq.sv
module pstg_seq
    import pstg_pkg::*;
#(
    parameter int INIT_CYC = 225000,
    parameter int SOFT_CYC = 32500,
    parameter int HOLD_CYC = 15000000
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_reset_n,
    input  logic sleep_n,
    input  logic ext_err_n,
    input  logic oc_ab,
    input  logic oc_cd,
    input  logic temp_hot,
    input  logic temp_cool,
    input  logic supply_low,
    output logic valid,
    output logic fault_n,
    output logic hiz_en,
    output logic outs_low,
    output logic hard_mute
);
    localparam int MAXC = max3(INIT_CYC, SOFT_CYC, HOLD_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic [IN_NUM-1:0] pin_vec;
    logic [IN_NUM-1:0] s_vec;
    logic s_rst_n, s_pdn_n, s_err_n;
    logic active;
    logic t_done, t_load;
    logic [CW-1:0] t_val;
    pstg_state_e state, nxt;
    pstg_out_t   ov;

    always_comb begin
        pin_vec          = '0;
        pin_vec[IN_RST]  = hw_reset_n;
        pin_vec[IN_PDN]  = sleep_n;
        pin_vec[IN_ERR]  = ext_err_n;
        pin_vec[IN_OCAB] = oc_ab;
        pin_vec[IN_OCCD] = oc_cd;
        pin_vec[IN_HOT]  = temp_hot;
        pin_vec[IN_COOL] = temp_cool;
        pin_vec[IN_LOW]  = supply_low;
    end

    pstg_sync #(.W(IN_NUM), .STAGES(2), .RST_VAL(IN_IDLE)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_vec),
        .dout (s_vec)
    );

    assign s_rst_n = s_vec[IN_RST];
    assign s_pdn_n = s_vec[IN_PDN];
    assign s_err_n = s_vec[IN_ERR];

    pstg_fault_trk u_trk (
        .clk     (clk),
        .rst     (rst),
        .rst_n_s (s_rst_n),
        .oc_ab_s (s_vec[IN_OCAB]),
        .oc_cd_s (s_vec[IN_OCCD]),
        .hot_s   (s_vec[IN_HOT]),
        .cool_s  (s_vec[IN_COOL]),
        .low_s   (s_vec[IN_LOW]),
        .active  (active)
    );

    // next state: reset > fault > power-down > external error
    always_comb begin
        nxt = state;
        if (!s_rst_n)
            nxt = ST_RESET;
        else if (active)
            nxt = ST_FAULT;
        else begin
            unique case (state)
                ST_RESET: nxt = s_pdn_n ? ST_INIT : ST_PDOWN;
                ST_INIT:  if (!s_pdn_n) nxt = ST_PDOWN;
                          else if (t_done) nxt = ST_RUN;
                ST_PDOWN: if (s_pdn_n) nxt = ST_SOFT;
                ST_SOFT:  if (!s_pdn_n) nxt = ST_PDOWN;
                          else if (t_done) nxt = ST_RUN;
                ST_RUN:   if (!s_pdn_n) nxt = ST_PDOWN;
                          else if (!s_err_n) nxt = ST_BKERR;
                ST_BKERR: if (!s_pdn_n) nxt = ST_PDOWN;
                          else if (t_done && s_err_n) nxt = ST_RUN;
                ST_FAULT: nxt = s_pdn_n ? ST_SOFT : ST_PDOWN;
                default:  nxt = ST_RESET;
            endcase
        end
    end

    always_comb begin
        t_load = (nxt != state);
        unique case (nxt)
            ST_INIT:  t_val = CW'(INIT_CYC - 1);
            ST_SOFT:  t_val = CW'(SOFT_CYC - 1);
            ST_BKERR: t_val = CW'(HOLD_CYC - 1);
            default:  t_val = '0;
        endcase
    end

    pstg_timer #(.W(CW)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (t_load),
        .ld_val (t_val),
        .done   (t_done)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_RESET;
        else
            state <= nxt;
    end

    assign ov        = decode(state);
    assign valid     = ov.valid;
    assign fault_n   = ov.fault_n;
    assign hiz_en    = ov.hiz_en;
    assign outs_low  = ov.outs_low;
    assign hard_mute = ov.hard_mute;

    AST_MUTE_ON_RESET: assert property (@(posedge clk) disable iff (rst)
        !s_rst_n |=> hard_mute && !valid); // R3
    AST_FAULT_HIZ: assert property (@(posedge clk) disable iff (rst)
        s_rst_n && active |=> hiz_en && !fault_n); // R7
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst)
        outs_low && !s_err_n && s_rst_n && s_pdn_n && !active |=> outs_low); // R11
    AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({valid, hiz_en, outs_low, hard_mute})); // R12
    AST_RUN_CLEAN: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(s_rst_n) && $past(!active)); // R12
endmodule

// File: tb/pstg_seq_bench.sv
module pstg_seq_bench;
    localparam int INIT = 20;
    localparam int SOFT = 10;
    localparam int HOLD = 30;

    // vector {valid, fault_n, hiz_en, outs_low, hard_mute}
    localparam logic [4:0] V_RUN  = 5'b11000;
    localparam logic [4:0] V_MUTE = 5'b00001;
    localparam logic [4:0] V_SOFT = 5'b00000;
    localparam logic [4:0] V_HIZ  = 5'b00100;
    localparam logic [4:0] V_LOW  = 5'b00010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hw_reset_n = 1'b0, sleep_n = 1'b1, ext_err_n = 1'b1;
    logic oc_ab = 1'b0, oc_cd = 1'b0, temp_hot = 1'b0, temp_cool = 1'b0, supply_low = 1'b0;
    logic valid, fault_n, hiz_en, outs_low, hard_mute;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pstg_seq #(.INIT_CYC(INIT), .SOFT_CYC(SOFT), .HOLD_CYC(HOLD)) u_pstg_seq (
        .clk(clk), .rst(rst), .hw_reset_n(hw_reset_n), .sleep_n(sleep_n),
        .ext_err_n(ext_err_n), .oc_ab(oc_ab), .oc_cd(oc_cd), .temp_hot(temp_hot),
        .temp_cool(temp_cool), .supply_low(supply_low), .valid(valid),
        .fault_n(fault_n), .hiz_en(hiz_en), .outs_low(outs_low), .hard_mute(hard_mute)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {valid, fault_n, hiz_en, outs_low, hard_mute};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // reset pin pulse then full start-up; leaves the block running
    task automatic reset_cycle();
        hw_reset_n = 1'b0;
        step(3);
        chk("R3", V_MUTE);
        step(3);
        hw_reset_n = 1'b1;
        step(3 + INIT);
        chk("R7", V_RUN);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1", V_MUTE);
        step(4);
        chk("R1", V_MUTE);

        // R4: start-up after reset release
        hw_reset_n = 1'b1;
        step(2 + INIT);
        chk("R4", V_MUTE);
        step(1);
        chk("R4", V_RUN);

        // R2 latency and R6 power-down / soft start
        sleep_n = 1'b0;
        step(2);
        chk("R2", V_RUN);
        step(1);
        chk("R6", V_MUTE);
        step(5);
        sleep_n = 1'b1;
        step(2);
        chk("R2", V_MUTE);
        step(SOFT);
        chk("R6", V_SOFT);
        step(1);
        chk("R6", V_RUN);

        // R10: short external error pulse
        ext_err_n = 1'b0;
        step(3);
        chk("R10", V_LOW);
        ext_err_n = 1'b1;
        step(HOLD - 1);
        chk("R10", V_LOW);
        step(1);
        chk("R10", V_RUN);

        // R11: error held past the hold time
        ext_err_n = 1'b0;
        step(3 + HOLD + 10);
        chk("R11", V_LOW);
        ext_err_n = 1'b1;
        step(2);
        chk("R11", V_LOW);
        step(1);
        chk("R11", V_RUN);

        // R3: reset from the error state
        ext_err_n = 1'b0;
        step(3);
        hw_reset_n = 1'b0;
        ext_err_n = 1'b1;
        step(3);
        chk("R3", V_MUTE);
        hw_reset_n = 1'b1;
        step(3 + INIT);
        chk("R4", V_RUN);

        // R7: overcurrent on each pair, latched until reset
        for (int p = 0; p < 2; p++) begin
            if (p == 0) oc_ab = 1'b1; else oc_cd = 1'b1;
            step(2);
            chk("R2", V_RUN);
            step(1);
            chk("R7", V_HIZ);
            oc_ab = 1'b0;
            oc_cd = 1'b0;
            step(12);
            chk("R7", V_HIZ);
            reset_cycle();
        end

        // R8: temperature pulse, held until cool flag
        temp_hot = 1'b1;
        step(2);
        temp_hot = 1'b0;
        step(10);
        chk("R8", V_HIZ);
        temp_cool = 1'b1;
        step(2);
        chk("R8", V_HIZ);
        step(1);
        chk("R8", V_SOFT);
        step(SOFT);
        chk("R8", V_RUN);
        temp_cool = 1'b0;
        step(4);
        chk("R8", V_RUN);

        // R9: supply low, self-clearing
        supply_low = 1'b1;
        step(3);
        chk("R9", V_HIZ);
        step(10);
        chk("R9", V_HIZ);
        supply_low = 1'b0;
        step(3);
        chk("R9", V_SOFT);
        step(SOFT);
        chk("R9", V_RUN);

        // R13: fault and external error on the same edge
        ext_err_n = 1'b0;
        oc_ab = 1'b1;
        step(3);
        chk("R13", V_HIZ);
        ext_err_n = 1'b1;
        oc_ab = 1'b0;
        step(3);
        reset_cycle();

        // R13: fault and power-down together
        sleep_n = 1'b0;
        supply_low = 1'b1;
        step(3);
        chk("R13", V_HIZ);
        supply_low = 1'b0;
        step(3);
        chk("R13", V_MUTE);
        sleep_n = 1'b1;
        step(3 + SOFT);
        chk("R6", V_RUN);

        // R5: reset released while power-down held
        hw_reset_n = 1'b0;
        sleep_n = 1'b0;
        step(5);
        hw_reset_n = 1'b1;
        step(3 + INIT + 5);
        chk("R5", V_MUTE);
        sleep_n = 1'b1;
        step(2 + SOFT);
        chk("R5", V_SOFT);
        step(1);
        chk("R5", V_RUN);
        chk("R12", V_RUN);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule